// File: doc/BRIEF.md
# I2C Control Register Bank

This block is a write-mostly target on a two-wire serial bus. It holds nine 8-bit control registers and returns one read-only status byte. All register contents appear on a flat parallel output, so the switching logic around the block can decode them directly. SCL and SDA are oversampled by a much faster system clock through two-stage synchronizers. START and STOP are recognised from SDA edges while SCL is high. The block answers on SDA only through an open-drain pull-down enable.

The 7-bit target address is `100101s`, where `s` is the strap input `addr_sel`. With the strap low, the block answers write byte 0x94 and read byte 0x95. With the strap high, it answers 0x96 and 0x97.

A write carries a register index followed by any number of data bytes. Each data byte lands in the current index, and the index then advances. Indices 0x00..0x08 hold storage. Bytes aimed at a higher index are acknowledged and dropped. A read has no index phase: the target sends one status byte that packs two 2-bit slow-blanking level codes, and then leaves the bus alone until the next START.

Top module: `ctlbank_i2c`

## Requirements
- R1: While reset is asserted and right after it is released, all nine registers read 0x00 and `sda_oe` is 0.
- R2: The block pulls SDA low during the ninth clock after an address byte whose upper seven bits are `100101` followed by `addr_sel`. This holds for both R/W values (bit 0 = 1 means read).
- R3: An address byte that does not match gets no acknowledge. After it the block drives nothing and writes nothing until the next START.
- R4: In a write, the first byte after the address is the register index, and the next byte is stored in that register. The block acknowledges both bytes.
- R5: Each further data byte before STOP is stored at the next index (auto-increment).
- R6: Data bytes aimed at an index above 0x08 are acknowledged and discarded. A burst that runs past 0x08 stops writing there, and all other registers stay unchanged.
- R7: A read sends one byte, MSB first. Bits [1:0] are `lvl_a`, bits [3:2] are `lvl_b` (01 = low level, 10 = wide-screen, 11 = normal aspect), and bits [7:4] are 0.
- R8: After the status byte, SDA stays released until the next START, even if the master acknowledges and keeps clocking.
- R9: A repeated START in the middle of a byte drops the partial byte without writing it, and address reception starts again.
- R10: After STOP, bytes clocked without a new START get no acknowledge and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Strap that sets the lowest target-address bit |
| lvl_a | input | 2 | Slow-blanking level code of the first connector |
| lvl_b | input | 2 | Slow-blanking level code of the second connector |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | 72 | Register i on bits [8i+7:8i] |

## Verification
The hardest case to reach is an auto-increment burst that crosses index 0x08. Storage must stop there while acknowledges continue. The bench starts a burst at index 0x07 and sends four bytes, then writes once to index 0x20. A reference array updated at each committed byte is compared with `regs_o` on every clock. The repeated-START abort is reached by cutting a data byte after four bits. The post-read release is reached by having the master acknowledge the status byte and clock a second byte, which must read as all ones.

// File: rtl/ctlbank_i2c.sv
module ctlbank_i2c #(
  parameter int NREG = 9,
  parameter logic [5:0] ADDR_HI = 6'b100101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel,
  input  logic [1:0]        lvl_a,
  input  logic [1:0]        lvl_b,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [2:0] P_IDLE = 3'd0;
  localparam logic [2:0] P_ADDR = 3'd1;
  localparam logic [2:0] P_SUB  = 3'd2;
  localparam logic [2:0] P_DATA = 3'd3;
  localparam logic [2:0] P_READ = 3'd4;

  logic [1:0] scl_q, sda_q;
  logic       scl_d, sda_d;
  logic [2:0] phase;
  logic [3:0] cnt;
  logic       in_ack;
  logic [7:0] sh, ptr;
  logic [6:0] tx;
  logic [7:0] bank [NREG];

  wire scl_s    = scl_q[1];
  wire sda_s    = sda_q[1];
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire rx_ph    = (phase == P_ADDR) || (phase == P_SUB) || (phase == P_DATA);
  wire [7:0] status = {4'b0000, lvl_b, lvl_a};
  wire [6:0] own    = {ADDR_HI, addr_sel};
  wire ptr_in       = ptr < 8'(NREG);

  for (genvar i = 0; i < NREG; i++) begin : g_out
    assign regs_o[i*8 +: 8] = bank[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= P_IDLE;
      cnt    <= '0;
      in_ack <= 1'b0;
      sh     <= '0;
      tx     <= '0;
      ptr    <= '0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else if (start_c) begin
      phase  <= P_ADDR;
      cnt    <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      phase  <= P_IDLE;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (scl_rise) begin
      if (rx_ph && !in_ack && cnt < 4'd8) begin
        sh  <= {sh[6:0], sda_s};
        cnt <= cnt + 4'd1;
      end else if (phase == P_READ && !in_ack) begin
        cnt <= cnt + 4'd1;
      end
    end else if (scl_fall) begin
      if (in_ack) begin
        in_ack <= 1'b0;
        cnt    <= '0;
        if (phase == P_READ) begin
          tx     <= status[6:0];
          sda_oe <= ~status[7];
        end else begin
          sda_oe <= 1'b0;
        end
      end else if (phase == P_READ) begin
        if (cnt == 4'd8) begin
          sda_oe <= 1'b0;
          phase  <= P_IDLE;
        end else begin
          tx     <= {tx[5:0], 1'b0};
          sda_oe <= ~tx[6];
        end
      end else if (rx_ph && cnt == 4'd8) begin
        case (phase)
          P_ADDR: begin
            if (sh[7:1] == own) begin
              in_ack <= 1'b1;
              sda_oe <= 1'b1;
              phase  <= sh[0] ? P_READ : P_SUB;
            end else begin
              phase <= P_IDLE;
            end
          end
          P_SUB: begin
            ptr    <= sh;
            in_ack <= 1'b1;
            sda_oe <= 1'b1;
            phase  <= P_DATA;
          end
          default: begin
            if (ptr_in) begin
              bank[ptr[IW-1:0]] <= sh;
              ptr <= ptr + 8'd1;
            end
            in_ack <= 1'b1;
            sda_oe <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ctlbank_i2c_chk.sv
module ctlbank_i2c_chk #(
  parameter int NREG = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [NREG*8-1:0] regs_o,
  input logic [2:0]        phase,
  input logic [7:0]        ptr
);
  assert_oe_moves_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0) |-> !sda_oe);

  assert_write_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> !scl_i);

  assert_no_store_past_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3 && ptr >= 8'(NREG)) |=> $stable(regs_o));

  assert_read_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4) |=> $stable(regs_o));
endmodule

bind ctlbank_i2c ctlbank_i2c_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .regs_o(regs_o), .phase(phase), .ptr(ptr)
);

// File: tb/sim_ctlbank_i2c.sv
`timescale 1ns/1ps
module sim_ctlbank_i2c;
  localparam int NR = 9;
  localparam int Q  = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, m_scl, m_sda, addr_sel;
  logic [1:0] lvl_a, lvl_b;
  logic sda_oe;
  logic [NR*8-1:0] regs_o;
  wire sda_line = m_sda & ~sda_oe;

  ctlbank_i2c u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .addr_sel(addr_sel), .lvl_a(lvl_a), .lvl_b(lvl_b),
    .sda_oe(sda_oe), .regs_o(regs_o)
  );

  int n_cmp = 0, n_bad = 0;
  int quiet = 0;
  int pend_idx = -1;
  int bptr = 0;
  bit done = 0;
  logic [7:0] exp_r [NR];

  task automatic chk(input string tag, input int act, input int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (quiet > 0) quiet--;
      else for (int i = 0; i < NR; i++)
        chk($sformatf("R4/R5/R6 reg%0d per-clock", i), int'(regs_o[i*8 +: 8]), int'(exp_r[i]));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(Q); m_scl = 1'b0; quiet = 12; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    if (pend_idx >= 0) exp_r[pend_idx] = b;
    pend_idx = -1;
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q/2);
    ack = !sda_line;
    tick(Q/2); m_scl = 1'b0; tick(Q);
  endtask

  task automatic read_byte(output logic [7:0] v, input logic mack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q/2);
      v[i] = sda_line;
      tick(Q/2); m_scl = 1'b0; tick(Q);
    end
    bit_out(!mack);
  endtask

  task automatic wr_txn(input logic [7:0] adr, input logic [7:0] sub,
                        input logic [7:0] d [4], input int n, input string tag);
    logic ack;
    bit hit;
    hit = (adr[7:1] == {6'b100101, addr_sel}) && !adr[0];
    bus_start();
    send_byte(adr, ack);
    chk({tag, " address ack"}, int'(ack), int'(hit));
    send_byte(sub, ack);
    chk({tag, " index ack"}, int'(ack), int'(hit));
    bptr = sub;
    for (int k = 0; k < n; k++) begin
      pend_idx = (hit && bptr < NR) ? bptr : -1;
      send_byte(d[k], ack);
      chk({tag, " data ack"}, int'(ack), int'(hit));
      if (bptr < NR) bptr++;
    end
    bus_stop();
    chk({tag, " released after stop"}, int'(sda_oe), 0);
  endtask

  task automatic rd_txn(input logic [7:0] adr, input logic [1:0] a, input logic [1:0] b,
                        input logic mack, input string tag);
    logic ack;
    logic [7:0] v;
    bit hit;
    lvl_a = a; lvl_b = b;
    hit = (adr[7:1] == {6'b100101, addr_sel}) && adr[0];
    bus_start();
    send_byte(adr, ack);
    chk({tag, " read address ack"}, int'(ack), int'(hit));
    read_byte(v, mack);
    chk({tag, " status byte"}, int'(v), hit ? int'({4'b0000, b, a}) : 8'hFF);
    if (mack) begin
      read_byte(v, 1'b0);
      chk("R8 bus released after status", int'(v), 8'hFF);
      chk("R8 no drive after status", int'(sda_oe), 0);
    end
    bus_stop();
  endtask

  task automatic chk_all(input string tag);
    for (int i = 0; i < NR; i++) chk(tag, int'(regs_o[i*8 +: 8]), int'(exp_r[i]));
  endtask

  initial begin
    logic ack;
    for (int i = 0; i < NR; i++) exp_r[i] = 8'h00;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; addr_sel = 1'b0; lvl_a = 2'b00; lvl_b = 2'b00;
    tick(5);
    chk("R1 oe in reset", int'(sda_oe), 0);
    chk("R1 regs in reset", int'(regs_o == '0), 1);
    rst_n = 1'b1;
    tick(3);
    chk_all("R1 regs after reset");

    wr_txn(8'h94, 8'h01, '{8'h3C, 8'h00, 8'h00, 8'h00}, 1, "R2 R4 single");
    wr_txn(8'h94, 8'h05, '{8'h11, 8'h22, 8'h33, 8'h00}, 3, "R5 burst");
    wr_txn(8'h94, 8'h07, '{8'hA1, 8'hA2, 8'hA3, 8'hA4}, 4, "R6 cross end");
    wr_txn(8'h94, 8'h20, '{8'hEE, 8'h00, 8'h00, 8'h00}, 1, "R6 high index");
    chk_all("R6 after discard");
    wr_txn(8'h96, 8'h00, '{8'h55, 8'h66, 8'h00, 8'h00}, 2, "R3 wrong address");
    chk_all("R3 regs untouched");

    rd_txn(8'h95, 2'b10, 2'b11, 1'b0, "R7 first");
    rd_txn(8'h95, 2'b01, 2'b10, 1'b0, "R7 second");

    addr_sel = 1'b1;
    wr_txn(8'h96, 8'h00, '{8'h77, 8'h00, 8'h00, 8'h00}, 1, "R2 strap high");
    wr_txn(8'h94, 8'h02, '{8'h99, 8'h00, 8'h00, 8'h00}, 1, "R2 old address ignored");
    rd_txn(8'h97, 2'b11, 2'b01, 1'b1, "R2 R7 R8 strap high read");
    addr_sel = 1'b0;

    bus_start();
    send_byte(8'h94, ack); chk("R9 address ack", int'(ack), 1);
    send_byte(8'h02, ack); chk("R9 index ack", int'(ack), 1);
    for (int k = 0; k < 4; k++) bit_out(1'b1);
    bus_start();
    send_byte(8'h94, ack); chk("R9 restart ack", int'(ack), 1);
    send_byte(8'h03, ack); chk("R9 restart index ack", int'(ack), 1);
    pend_idx = 3;
    send_byte(8'h5A, ack); chk("R9 restart data ack", int'(ack), 1);
    bus_stop();
    chk("R9 partial byte dropped", int'(regs_o[2*8 +: 8]), int'(exp_r[2]));
    chk("R9 new write landed", int'(regs_o[3*8 +: 8]), 8'h5A);

    send_byte(8'h94, ack); chk("R10 no ack after stop", int'(ack), 0);
    send_byte(8'hC3, ack); chk("R10 no ack second byte", int'(ack), 0);
    chk_all("R10 regs unchanged");

    tick(20);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule